// File: doc/BRIEF.md
# Credit-Throttled Pipelined Link

This block carries words from a sending side to a receiving FIFO across a link whose forward data path and backward credit path are each built from a configurable number of register stages. There is no stall wire running back to the sender. Instead, the sender keeps a count of the receiver FIFO entries it may still fill. It spends one credit for every word it launches and stops launching when the count reaches zero. Each time the consumer takes a word out of the receiver FIFO, one credit travels back through the credit pipeline and refills the count.

Only the receiver FIFO entries hold credits. The link stages in between are never counted as storage. The starting credit count is a parameter. Setting it to the FIFO depth, when the credit loop is short enough, gives one word per cycle. Setting it lower makes the link pause early and wait for credits, which costs bandwidth but never loses a word. The producer uses a valid/ready pair at the enqueue port and the consumer uses a valid/ready pair at the dequeue port.

Top module: `credit_link`

## Requirements
- R1: After reset, enqReady is 1 (the credit count starts at INIT_CREDITS, which is at least 1), deqValid is 0 and overflowErr is 0.
- R2: enqReady is 0 whenever the credit count is zero, and while it is 0 no word is accepted, whatever enqValid does.
- R3: The credit count drops by one at every accepted enqueue and rises by one at every credit arrival. When both happen in the same cycle it is unchanged. It never exceeds INIT_CREDITS.
- R4: A dequeue at clock edge j sends one credit that reaches the counter at edge j+BWD_STAGES. Link stage registers hold no credit.
- R5: A word accepted at edge k is written into the receiver FIFO at edge k+FWD_STAGES and is presented on deqValid/deqData right after that edge.
- R6: Words leave the dequeue port in the order they were accepted, under any pattern of deqReady back-pressure.
- R7: overflowErr is a sticky flag that is set if a word arrives while the receiver FIFO is full. With INIT_CREDITS no larger than FIFO_DEPTH it never rises.
- R8: With INIT_CREDITS at least FWD_STAGES+BWD_STAGES+2 and deqReady held at 1, a continuously valid producer is accepted on every cycle.
- R9: With INIT_CREDITS set to 1, a continuously valid producer is accepted exactly once every FWD_STAGES+BWD_STAGES+2 cycles. Every word still arrives, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enqValid | input | 1 | Producer has a word |
| enqData | input | DATA_W | Producer word |
| enqReady | output | 1 | A credit is available, so the word is taken this edge |
| deqValid | output | 1 | Receiver FIFO holds a word |
| deqData | output | DATA_W | Head word of the receiver FIFO |
| deqReady | input | 1 | Consumer takes the head word this edge |
| overflowErr | output | 1 | Sticky: a word arrived at a full receiver FIFO |

## Verification
A word taken at edge k is due on the dequeue port FWD_STAGES edges later. The credit for a word dequeued at edge j is due in the counter BWD_STAGES edges later, so enqReady can only recover one cycle after that. The bench keeps a behavioural model that records each word and each credit together with the edge number at which it falls due. It applies the model's view at each edge and compares enqReady, deqValid, deqData and overflowErr at every falling clock edge, where all registers have settled. Throughput is measured by counting handshakes over a fixed window: on the default instance the expected count is one per cycle, and on a second instance with one credit it is one per loop period.

// File: rtl/credit_link_pkg.sv
package credit_link_pkg;
  // Strobes from the control to the datapath
  typedef struct packed {
    logic push;  // word launched onto the forward link
    logic pop;   // head word leaves the receiver FIFO
  } linkStrobes_t;
endpackage

// File: rtl/credit_ctrl.sv
module credit_ctrl
  import credit_link_pkg::*;
#(
  parameter int INIT_CREDITS = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         enqValid,
  output logic         enqReady,
  input  logic         deqReady,
  input  logic         fifoNotEmpty,
  input  logic         creditRet,
  output linkStrobes_t strobes
);
  localparam int CNT_W = $clog2(INIT_CREDITS + 1);
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(INIT_CREDITS);

  logic [CNT_W-1:0] credits;

  assign enqReady     = (credits != '0);
  assign strobes.push = enqValid && enqReady;
  assign strobes.pop  = deqReady && fifoNotEmpty;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      credits <= CNT_INIT;
    end else begin
      case ({strobes.push, creditRet})
        2'b10:   credits <= credits - 1'b1;
        2'b01:   credits <= credits + 1'b1;
        default: credits <= credits;
      endcase
    end
  end

  AST_CREDIT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    credits <= CNT_INIT);  // R3
  AST_CREDIT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.push && creditRet) |=> $stable(credits));  // R3
  AST_CREDIT_DEC: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.push && !creditRet) |=> (credits == $past(credits) - 1'b1));  // R3
  AST_NO_SEND_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (credits == '0 && !creditRet) |=> (credits == '0 || $past(creditRet)));  // R2
endmodule

// File: rtl/credit_dpath.sv
module credit_dpath
  import credit_link_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 4,
  parameter int FWD_STAGES = 1,
  parameter int BWD_STAGES = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  linkStrobes_t      strobes,
  input  logic [DATA_W-1:0] enqData,
  output logic [DATA_W-1:0] deqData,
  output logic              fifoNotEmpty,
  output logic              creditRet,
  output logic              overflowErr
);
  localparam int PTR_W = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(FIFO_DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FIFO_DEPTH);

  // Forward link stages
  logic [FWD_STAGES-1:0] fwdValid;
  logic [DATA_W-1:0]     fwdData [FWD_STAGES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fwdValid <= '0;
    end else begin
      fwdValid[0] <= strobes.push;
      for (int i = 1; i < FWD_STAGES; i++) fwdValid[i] <= fwdValid[i-1];
    end
  end

  always_ff @(posedge clk) begin
    fwdData[0] <= enqData;
    for (int i = 1; i < FWD_STAGES; i++) fwdData[i] <= fwdData[i-1];
  end

  // Receiver FIFO
  logic [DATA_W-1:0] mem [FIFO_DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  count;
  logic              arrive, full, fifoWr;

  assign arrive       = fwdValid[FWD_STAGES-1];
  assign full         = (count == CNT_FULL);
  assign fifoWr       = arrive && !full;
  assign fifoNotEmpty = (count != '0);
  assign deqData      = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (fifoWr) mem[wrPtr] <= fwdData[FWD_STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr       <= '0;
      rdPtr       <= '0;
      count       <= '0;
      overflowErr <= 1'b0;
    end else begin
      if (fifoWr)      wrPtr <= (wrPtr == PTR_LAST) ? '0 : wrPtr + 1'b1;
      if (strobes.pop) rdPtr <= (rdPtr == PTR_LAST) ? '0 : rdPtr + 1'b1;
      case ({fifoWr, strobes.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (arrive && full) overflowErr <= 1'b1;
    end
  end

  // Backward credit stages
  logic [BWD_STAGES-1:0] bwdCredit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bwdCredit <= '0;
    end else begin
      bwdCredit[0] <= strobes.pop;
      for (int i = 1; i < BWD_STAGES; i++) bwdCredit[i] <= bwdCredit[i-1];
    end
  end

  assign creditRet = bwdCredit[BWD_STAGES-1];

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    arrive |-> !full);  // R7
  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rstN)
    strobes.pop |-> (count != '0));  // R6
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_FULL);  // R7
  AST_CREDIT_LAUNCH: assert property (@(posedge clk) disable iff (!rstN)
    strobes.pop |=> bwdCredit[0]);  // R4
endmodule

// File: rtl/credit_link.sv
module credit_link
  import credit_link_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int FIFO_DEPTH   = 4,
  parameter int INIT_CREDITS = 4,
  parameter int FWD_STAGES   = 1,
  parameter int BWD_STAGES   = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enqValid,
  input  logic [DATA_W-1:0] enqData,
  output logic              enqReady,
  output logic              deqValid,
  output logic [DATA_W-1:0] deqData,
  input  logic              deqReady,
  output logic              overflowErr
);
  linkStrobes_t strobes;
  logic         fifoNotEmpty;
  logic         creditRet;

  credit_ctrl #(
    .INIT_CREDITS(INIT_CREDITS)
  ) i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .enqValid    (enqValid),
    .enqReady    (enqReady),
    .deqReady    (deqReady),
    .fifoNotEmpty(fifoNotEmpty),
    .creditRet   (creditRet),
    .strobes     (strobes)
  );

  credit_dpath #(
    .DATA_W    (DATA_W),
    .FIFO_DEPTH(FIFO_DEPTH),
    .FWD_STAGES(FWD_STAGES),
    .BWD_STAGES(BWD_STAGES)
  ) i_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .enqData     (enqData),
    .deqData     (deqData),
    .fifoNotEmpty(fifoNotEmpty),
    .creditRet   (creditRet),
    .overflowErr (overflowErr)
  );

  assign deqValid = fifoNotEmpty;
endmodule

// File: tb/test_credit_link.sv
module test_credit_link;
  localparam int DW = 8;
  localparam int FD = 4;
  localparam int IC = 4;
  localparam int FS = 1;
  localparam int BS = 1;
  localparam int LOW_FS = 2;
  localparam int LOW_BS = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic          enqValid = 1'b0, deqReady = 1'b0;
  logic [DW-1:0] enqData = '0;
  logic          enqReady, deqValid, overflowErr;
  logic [DW-1:0] deqData;

  logic          lEnqValid = 1'b0, lDeqReady = 1'b0;
  logic [DW-1:0] lEnqData = '0;
  logic          lEnqReady, lDeqValid, lOverflowErr;
  logic [DW-1:0] lDeqData;

  credit_link #(.DATA_W(DW), .FIFO_DEPTH(FD), .INIT_CREDITS(IC),
                .FWD_STAGES(FS), .BWD_STAGES(BS)) i_credit_link (
    .clk(clk), .rstN(rstN), .enqValid(enqValid), .enqData(enqData),
    .enqReady(enqReady), .deqValid(deqValid), .deqData(deqData),
    .deqReady(deqReady), .overflowErr(overflowErr));

  credit_link #(.DATA_W(DW), .FIFO_DEPTH(2), .INIT_CREDITS(1),
                .FWD_STAGES(LOW_FS), .BWD_STAGES(LOW_BS)) i_credit_link_low (
    .clk(clk), .rstN(rstN), .enqValid(lEnqValid), .enqData(lEnqData),
    .enqReady(lEnqReady), .deqValid(lDeqValid), .deqData(lDeqData),
    .deqReady(lDeqReady), .overflowErr(lOverflowErr));

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Behavioural model: words and credits tagged with the edge they fall due
  int credits = IC;
  int fifoQ[$];
  int flightData[$];
  int flightEdge[$];
  int retEdge[$];
  int curEdge = 0;
  int nextData = 0;
  int sentCnt = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (edge %0d)", req, act, exp, curEdge);
    end
  endtask

  // Called at a falling edge: compare, drive, advance model by one edge
  task automatic step(input bit v, input bit r);
    bit snd, rd;
    chk("R2/R3 enqReady", int'(enqReady), int'(credits > 0));
    chk("R5 deqValid", int'(deqValid), int'(fifoQ.size() > 0));
    if (fifoQ.size() > 0) chk("R6 deqData order", int'(deqData), fifoQ[0]);
    chk("R7 overflowErr", int'(overflowErr), 0);
    enqValid = v;
    enqData  = DW'(nextData);
    deqReady = r;
    snd = v && (credits > 0);
    rd  = r && (fifoQ.size() > 0);
    if (rd) begin
      void'(fifoQ.pop_front());
      retEdge.push_back(curEdge + BS);  // R4
    end
    if (snd) begin
      flightData.push_back(nextData % (1 << DW));
      flightEdge.push_back(curEdge + FS);
      nextData++;
      sentCnt++;
    end
    while (flightEdge.size() > 0 && flightEdge[0] == curEdge) begin
      fifoQ.push_back(flightData.pop_front());
      void'(flightEdge.pop_front());
    end
    if (snd) credits--;
    while (retEdge.size() > 0 && retEdge[0] == curEdge) begin
      credits++;
      void'(retEdge.pop_front());
    end
    curEdge++;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    int startCnt;
    int lSent, lExp, lRecv;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 enqReady", int'(enqReady), 1);
    chk("R1 deqValid", int'(deqValid), 0);
    chk("R1 overflowErr", int'(overflowErr), 0);
    chk("R1 low enqReady", int'(lEnqReady), 1);
    rstN = 1'b1;

    // R8: full throughput, no back-pressure
    startCnt = sentCnt;
    for (int i = 0; i < 30; i++) step(1'b1, 1'b1);
    chk("R8 one word per cycle", sentCnt - startCnt, 30);

    // drain, then R2: consumer stopped, exactly INIT_CREDITS words accepted
    for (int i = 0; i < 10; i++) step(1'b0, 1'b1);
    startCnt = sentCnt;
    for (int i = 0; i < 12; i++) step(1'b1, 1'b0);
    chk("R2 sends limited by credits", sentCnt - startCnt, IC);
    chk("R2 enqReady low at zero credits", int'(enqReady), 0);

    // R4/R3: single dequeue returns one credit
    step(1'b1, 1'b1);
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0);

    // R6: random back-pressure
    for (int i = 0; i < 400; i++) step(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)));
    for (int i = 0; i < 12; i++) step(1'b0, 1'b1);
    chk("R6 all words delivered", fifoQ.size() + flightData.size(), 0);

    // R9: reduced credits on the low instance
    lSent = 0;
    lRecv = 0;
    lDeqReady = 1'b1;
    for (int i = 0; i < 42; i++) begin
      if (lDeqValid) begin
        chk("R9 low order", int'(lDeqData), lRecv);
        lRecv++;
      end
      lEnqValid = 1'b1;
      lEnqData  = DW'(lSent);
      if (lEnqReady) lSent++;
      @(posedge clk);
      @(negedge clk);
    end
    lEnqValid = 1'b0;
    lExp = (42 + LOW_FS + LOW_BS + 1) / (LOW_FS + LOW_BS + 2);
    chk("R9 low throughput", lSent, lExp);
    for (int i = 0; i < 10; i++) begin
      if (lDeqValid) begin
        chk("R9 low order", int'(lDeqData), lRecv);
        lRecv++;
      end
      @(posedge clk);
      @(negedge clk);
    end
    chk("R9 no word lost", lRecv, lSent);
    chk("R7 low overflowErr", int'(lOverflowErr), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule